// File: doc/BRIEF.md
# Daisy-Chain Interrupt Acknowledge Controller

A row of interrupt-source nodes shares a single interrupt request line to a processor. Each node watches one request input and turns a rising edge on it into a pending flag that stays set until the node is serviced, so a request that lasts only one cycle is not lost. The processor's interrupt line is high whenever any node has a pending flag.

When the processor raises its acknowledge, the acknowledge enters node 0 and walks toward the last node. A node without a pending flag passes it on. The first node that has a pending flag keeps it, places its own configured vector on the shared vector bus and blocks the acknowledge from reaching the nodes behind it. Priority therefore follows position alone, with node 0 highest. The choice is frozen at the start of the acknowledge. When the acknowledge ends, the winning node's pending flag is cleared. If no node claims the acknowledge, the bus carries a fixed spurious vector and the acknowledge is passed out of the end of the chain.

Top module: `irq_ack_chain`

## Requirements
- R1: While and after reset, with no request edge seen, `intr_out` is 0, `ack_pass_out` is 0 and `vec_bus` equals the spurious vector (default 8'hFF).
- R2: A 0-to-1 change of `src_req[i]` between two clock edges sets node i pending. `intr_out` is 1 after that edge, even if the request lasted one cycle.
- R3: A request held high raises one pending flag only. Once it has been serviced, `intr_out` stays 0 until the request falls and rises again.
- R4: `intr_out` is 1 exactly while at least one node is pending. It stays 1 after one node is serviced while another is still pending.
- R5: On the first clock edge with `ack_in` high, the pending node with the lowest index wins. Its vector is on `vec_bus` from the next cycle for as long as `ack_in` stays high.
- R6: The winner is fixed for the whole acknowledge. A request that arrives while `ack_in` is high does not change `vec_bus` until the acknowledge ends.
- R7: If no node is pending when the acknowledge starts, `vec_bus` holds the spurious vector and `ack_pass_out` is 1 while `ack_in` stays high. When a node claims the acknowledge, `ack_pass_out` is 0.
- R8: On the first edge with `ack_in` low after an acknowledge, only the winner's pending flag clears. `vec_bus` returns to the spurious vector, and other pending nodes stay pending.
- R9: At most one node drives `vec_bus` in any cycle. The bus shows exactly one node's vector, never a merge of several.
- R10: The vector of node i is `cfg_vectors[i*VEC_W +: VEC_W]` and is sampled while the node is granted, so a changed configuration shows on the next acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NODES | Per-node interrupt requests, rising-edge latched |
| cfg_vectors | input | NODES*VEC_W | Packed per-node identifying vectors, node 0 in the low bits |
| intr_out | output | 1 | Shared interrupt request line to the processor |
| ack_in | input | 1 | Acknowledge from the processor, high for the whole acknowledge cycle |
| vec_bus | output | VEC_W | Vector of the granted node, or the spurious vector |
| ack_pass_out | output | 1 | Acknowledge passed beyond the last node (no node claimed it) |

## Verification
A table drives single requests, pairs, all nodes at once and no request at all through one acknowledge each. This tells lowest-index priority apart from highest-index priority or from a merge of vectors, and it checks the spurious case. Directed sequences then hold a request high across service to separate edge latching from level latching, and raise a higher-priority request in the middle of an acknowledge to show that the grant is frozen. They also change a node's vector between acknowledges to show where the bus value comes from. After each acknowledge the interrupt line is checked, which shows whether only the winner was cleared.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    // Phase of the processor acknowledge as seen by the chain
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_HOLD = 1'b1
    } ack_phase_e;

endpackage

// File: rtl/irq_chain_link.sv
// One node of the acknowledge chain: keeps the acknowledge when pending,
// otherwise hands it to the next node.
module irq_chain_link (
    input  logic ack_i,
    input  logic pend_i,
    output logic claim_o,
    output logic pass_o
);

    assign claim_o = ack_i & pend_i;
    assign pass_o  = ack_i & ~pend_i;

endmodule

// File: rtl/irq_chain_walk.sv
// Ripples an acknowledge from node 0 upward; the first pending node claims it.
module irq_chain_walk #(
    parameter int NODES = 4
) (
    input  logic [NODES-1:0] pend_i,
    output logic [NODES-1:0] win_o,
    output logic             none_o
);

    logic [NODES:0] ack_w;

    assign ack_w[0] = 1'b1;

    for (genvar i = 0; i < NODES; i++) begin : g_link
        irq_chain_link u_link (
            .ack_i  (ack_w[i]),
            .pend_i (pend_i[i]),
            .claim_o(win_o[i]),
            .pass_o (ack_w[i+1])
        );
    end

    assign none_o = ack_w[NODES];

endmodule

// File: rtl/irq_vec_select.sv
// Places the granted node's vector on the bus; spurious value when none.
module irq_vec_select #(
    parameter int              NODES    = 4,
    parameter int              VEC_W    = 8,
    parameter logic [VEC_W-1:0] SPURIOUS = '1
) (
    input  logic [NODES-1:0]       sel_i,
    input  logic [NODES*VEC_W-1:0] vecs_i,
    output logic [VEC_W-1:0]       bus_o
);

    logic [VEC_W-1:0] acc_w [NODES+1];

    assign acc_w[0] = '0;

    for (genvar i = 0; i < NODES; i++) begin : g_or
        assign acc_w[i+1] = acc_w[i] | ({VEC_W{sel_i[i]}} & vecs_i[i*VEC_W +: VEC_W]);
    end

    assign bus_o = (|sel_i) ? acc_w[NODES] : SPURIOUS;

endmodule

// File: rtl/irq_ack_chain.sv
module irq_ack_chain
    import irq_chain_pkg::*;
#(
    parameter int               NODES    = 4,
    parameter int               VEC_W    = 8,
    parameter logic [VEC_W-1:0] SPURIOUS = '1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NODES-1:0]       src_req,
    input  logic [NODES*VEC_W-1:0] cfg_vectors,
    output logic                   intr_out,
    input  logic                   ack_in,
    output logic [VEC_W-1:0]       vec_bus,
    output logic                   ack_pass_out
);

    typedef struct packed {
        logic [NODES-1:0] src_seen;
        logic [NODES-1:0] pend;
        logic [NODES-1:0] grant;
        ack_phase_e       phase;
        logic             pass;
    } chain_state_t;

    localparam chain_state_t RESET_STATE = '{
        src_seen: '0,
        pend:     '0,
        grant:    '0,
        phase:    PH_IDLE,
        pass:     1'b0
    };

    chain_state_t st_d, st_q;

    logic [NODES-1:0] win_w;
    logic             none_w;
    logic [NODES-1:0] grant_w;

    irq_chain_walk #(.NODES(NODES)) u_walk (
        .pend_i(st_q.pend),
        .win_o (win_w),
        .none_o(none_w)
    );

    always_comb begin
        logic [NODES-1:0] rise_v;
        logic [NODES-1:0] clr_v;
        st_d     = st_q;
        rise_v   = src_req & ~st_q.src_seen;
        clr_v    = '0;
        st_d.src_seen = src_req;
        case (st_q.phase)
            PH_IDLE: begin
                if (ack_in) begin
                    st_d.phase = PH_HOLD;
                    st_d.grant = win_w;
                    st_d.pass  = none_w;
                end
            end
            PH_HOLD: begin
                if (!ack_in) begin
                    st_d.phase = PH_IDLE;
                    clr_v      = st_q.grant;
                    st_d.grant = '0;
                    st_d.pass  = 1'b0;
                end
            end
            default: st_d = RESET_STATE;
        endcase
        st_d.pend = (st_q.pend & ~clr_v) | rise_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RESET_STATE;
        else        st_q <= st_d;
    end

    assign grant_w      = st_q.grant;
    assign intr_out     = |st_q.pend;
    assign ack_pass_out = st_q.pass;

    irq_vec_select #(
        .NODES   (NODES),
        .VEC_W   (VEC_W),
        .SPURIOUS(SPURIOUS)
    ) u_sel (
        .sel_i (grant_w),
        .vecs_i(cfg_vectors),
        .bus_o (vec_bus)
    );

endmodule

// File: rtl/irq_ack_chain_chk.sv
module irq_ack_chain_chk #(
    parameter int               NODES    = 4,
    parameter int               VEC_W    = 8,
    parameter logic [VEC_W-1:0] SPURIOUS = '1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NODES-1:0] src_req,
    input logic             intr_out,
    input logic             ack_in,
    input logic [VEC_W-1:0] vec_bus,
    input logic             ack_pass_out,
    input logic [NODES-1:0] grant
);

    // R2: a request edge leaves the interrupt line high after the next edge
    a_r2_edge_raises_line: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src_req & ~$past(src_req))) |=> intr_out);

    // R5: a granted node is still pending, so the line stays up
    a_r5_grant_implies_line: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> intr_out);

    // R6: once the grant is in place the bus does not move during the acknowledge
    a_r6_frozen_vector: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && ack_in && $past(ack_in) && $past(ack_in, 2)) |-> $stable(vec_bus));

    // R7: an unclaimed acknowledge leaves the spurious vector on the bus
    a_r7_spurious_on_pass: assert property (@(posedge clk) disable iff (!rst_n)
        ack_pass_out |-> (vec_bus == SPURIOUS));

    // R8: after the acknowledge ends the bus returns to the spurious vector
    a_r8_release_bus: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_in) |=> (vec_bus == SPURIOUS));

    // R9: at most one node drives the bus
    a_r9_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

endmodule

bind irq_ack_chain irq_ack_chain_chk #(
    .NODES   (NODES),
    .VEC_W   (VEC_W),
    .SPURIOUS(SPURIOUS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_req     (src_req),
    .intr_out    (intr_out),
    .ack_in      (ack_in),
    .vec_bus     (vec_bus),
    .ack_pass_out(ack_pass_out),
    .grant       (grant_w)
);

// File: tb/irq_ack_chain_test.sv
module irq_ack_chain_test;

    localparam int          CLK_PERIOD = 10;
    localparam int          N          = 4;
    localparam int          W          = 8;
    localparam logic [7:0]  SPUR       = 8'hFF;
    localparam int          ROWS       = 7;

    // request mask pulsed, expected winning node (N = nobody)
    localparam logic [3:0] T_MASK [ROWS] = '{4'b0001, 4'b0110, 4'b1000, 4'b1111,
                                             4'b1010, 4'b0100, 4'b0000};
    localparam int         T_WIN  [ROWS] = '{0, 1, 3, 0, 1, 2, 4};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_req = '0;
    logic [N*W-1:0] cfg_vectors = {8'hC3, 8'h3C, 8'hA5, 8'h5A};
    logic         intr_out;
    logic         ack_in = 1'b0;
    logic [W-1:0] vec_bus;
    logic         ack_pass_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    irq_ack_chain #(.NODES(N), .VEC_W(W), .SPURIOUS(SPUR)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_req     (src_req),
        .cfg_vectors (cfg_vectors),
        .intr_out    (intr_out),
        .ack_in      (ack_in),
        .vec_bus     (vec_bus),
        .ack_pass_out(ack_pass_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] vec_of(input int idx);
        return (idx >= N) ? SPUR : cfg_vectors[idx*W +: W];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic [N-1:0] mask);
        src_req = mask;
        step();
        src_req = '0;
    endtask

    task automatic ack_open();
        ack_in = 1'b1;
        step();
    endtask

    task automatic ack_close();
        ack_in = 1'b0;
        step();
    endtask

    task automatic drain();
        for (int k = 0; k < N + 1; k++) begin
            if (intr_out) begin
                ack_open();
                ack_close();
            end
        end
    endtask

    initial begin
        step(3);
        check("R1 intr_out in reset", intr_out, 0);
        check("R1 vec_bus in reset", vec_bus, SPUR);
        rst_n = 1'b1;
        step();
        check("R1 intr_out after reset", intr_out, 0);
        check("R1 ack_pass_out after reset", ack_pass_out, 0);
        check("R1 vec_bus after reset", vec_bus, SPUR);

        // Table walk: one acknowledge per row
        for (int r = 0; r < ROWS; r++) begin
            logic [N-1:0] rem;
            rem = T_MASK[r];
            if (T_WIN[r] < N) rem[T_WIN[r]] = 1'b0;
            pulse(T_MASK[r]);
            check("R2 line after pulse", intr_out, (T_MASK[r] != 0));
            ack_open();
            check("R5 R9 winner vector", vec_bus, vec_of(T_WIN[r]));
            check("R7 pass flag", ack_pass_out, (T_WIN[r] >= N));
            step();
            check("R6 vector held", vec_bus, vec_of(T_WIN[r]));
            ack_close();
            check("R4 R8 line after service", intr_out, (rem != 0));
            check("R8 bus released", vec_bus, SPUR);
            drain();
        end

        // R3: request held high is latched once
        src_req = 4'b0100;
        step();
        ack_open();
        check("R3 held request vector", vec_bus, vec_of(2));
        ack_close();
        step(3);
        check("R3 no relatch while held", intr_out, 0);
        src_req = '0;
        step();
        src_req = 4'b0100;
        step();
        check("R3 relatch after new edge", intr_out, 1);
        src_req = '0;
        drain();

        // R6: higher-priority request during an acknowledge
        pulse(4'b0100);
        ack_open();
        check("R6 initial grant", vec_bus, vec_of(2));
        pulse(4'b0001);
        step();
        check("R6 grant frozen", vec_bus, vec_of(2));
        ack_close();
        check("R8 other node stays pending", intr_out, 1);
        ack_open();
        check("R5 late high-priority node", vec_bus, vec_of(0));
        ack_close();
        check("R8 all serviced", intr_out, 0);

        // R10: reconfigured vector shows on next acknowledge
        cfg_vectors[3*W +: W] = 8'h5E;
        pulse(4'b1000);
        ack_open();
        check("R10 new vector for node 3", vec_bus, 8'h5E);
        ack_close();

        // R7: claimed acknowledge does not pass out
        pulse(4'b0010);
        ack_open();
        check("R7 pass low when claimed", ack_pass_out, 0);
        ack_close();
        check("R8 line low at end", intr_out, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule